// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Controller

This block steers operands for a five-stage pipeline (fetch, decode, execute, data access, write-back). Each cycle it looks at the instruction waiting in decode: up to three source register numbers, each with its own use flag, plus the destination, write enable and kind of that instruction. It keeps its own record of the destinations held in the execute/memory and memory/write-back pipeline registers. For every source it picks where the execute stage takes its operand from: the register file, the execute/memory result, or the memory/write-back result. When no forwarding path can provide the value in time, it holds decode and sends a bubble into execute.

The decode side is a valid/ready stream. An instruction moves into execute on a clock edge where `dec_valid_i` and `dec_ready_o` are both high. `dec_ready_o` depends only on the presented register fields and on stage state, never on `dec_valid_i`. While it is low, upstream must hold the same instruction stable: the PC and the decode register keep their values. Stages after decode never apply back-pressure.

An instruction that moves into execute shows up one cycle later as `ex_valid_o`, with its selects on `ex_fwd_sel_o`. In any cycle where nothing moves into execute, a bubble enters execute in its place.

A multi-register load is presented with its destination field set to the highest-numbered register in its list. That register is the one written last.

Top module: `hz_fwd_unit`

## Requirements
- R1: After reset, `ex_valid_o` is 0, every select is 0, `dec_ready_o` is 1, and no instruction from before the reset causes a forward or a stall.
- R2: A source that matches the destination of the instruction directly ahead gets select 1 (execute/memory result) while it is in execute. Select codes are 0 = register file, 1 = execute/memory, 2 = memory/write-back.
- R3: A source that matches the destination of the instruction two ahead, with no closer match, gets select 2.
- R4: If both older instructions write the same source register, the closer one wins and the select is 1.
- R5: A single load (kind 1) followed at once by an instruction that reads its destination stalls decode for exactly one cycle. The reader then gets select 2.
- R6: With one instruction between a single load and its reader, there is no stall and the reader gets select 2.
- R7: For a multi-register load (kind 2), a reader of its destination directly behind it stalls two cycles, and a reader with one instruction between stalls one cycle. In both cases the reader then takes the register file (select 0).
- R8: An older instruction whose write enable is clear causes neither forwarding nor a stall.
- R9: A destination equal to the program-counter register (15 by default) causes neither forwarding nor a stall.
- R10: A source whose use flag is clear gets select 0 and causes no stall.
- R11: While stalled, `stall_o` is high and `dec_ready_o` is low. The next cycle `ex_valid_o` is 0 (a bubble). `stall_o` is high only when `dec_valid_i` is high.
- R12: The three sources are judged independently. Source i uses bits [2i+1:2i] of `ex_fwd_sel_o` and bits [4i+3:4i] of `dec_src_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid_i | input | 1 | Decode holds an instruction |
| dec_ready_o | output | 1 | Decode instruction may move into execute |
| dec_src_i | input | 12 | Three packed source register numbers |
| dec_src_use_i | input | 3 | Per-source read flag |
| dec_dst_i | input | 4 | Destination register (highest listed one for multi-load) |
| dec_wen_i | input | 1 | Instruction writes its destination |
| dec_kind_i | input | 2 | 0 ALU, 1 single load, 2 multi-register load |
| stall_o | output | 1 | Hold PC and decode, insert bubble into execute |
| ex_valid_o | output | 1 | Execute stage holds a real instruction |
| ex_fwd_sel_o | output | 6 | Per-source operand select for the execute stage |

## Verification
The hardest situation to reach is a reader that waits out a multi-register load. Here the stall has to hold for two cycles, drop at exactly the right edge, and then leave the select pointing at the register file, because the load has already left both forwarding registers. The stimulus table gets there by placing a reader directly behind a multi-load, and later one reader a slot further back. It counts the cycles in which ready is low and checks that a bubble reaches execute during each of them. Separate entries put matching destinations into both pipeline registers at once, so that the priority between the two forwarding paths is exercised.

// File: rtl/hz_fwd_pkg.sv
package hz_fwd_pkg;
  typedef enum logic [1:0] {
    KIND_ALU   = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_MULTI = 2'd2
  } hz_kind_e;

  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_EXM = 2'd1,
    SEL_MWB = 2'd2
  } hz_sel_e;
endpackage

// File: rtl/hz_dest_pipe.sv
module hz_dest_pipe
  import hz_fwd_pkg::*;
#(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic [RW-1:0] dst_i,
  input  logic          wen_i,
  input  hz_kind_e      kind_i,
  output logic [RW-1:0] exm_dst_o,
  output logic          exm_wen_o,
  output hz_kind_e      exm_kind_o,
  output logic [RW-1:0] mwb_dst_o,
  output logic          mwb_wen_o,
  output hz_kind_e      mwb_kind_o
);
  // exm_*: instruction in execute, result lands in execute/memory register
  // mwb_*: instruction in data access, result lands in memory/write-back register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exm_dst_o  <= '0;
      exm_wen_o  <= 1'b0;
      exm_kind_o <= KIND_ALU;
      mwb_dst_o  <= '0;
      mwb_wen_o  <= 1'b0;
      mwb_kind_o <= KIND_ALU;
    end else begin
      exm_dst_o  <= dst_i;
      exm_wen_o  <= adv_i & wen_i;
      exm_kind_o <= adv_i ? kind_i : KIND_ALU;
      mwb_dst_o  <= exm_dst_o;
      mwb_wen_o  <= exm_wen_o;
      mwb_kind_o <= exm_kind_o;
    end
  end
endmodule

// File: rtl/hz_src_check.sv
module hz_src_check
  import hz_fwd_pkg::*;
#(
  parameter int RW     = 4,
  parameter int PC_REG = 15
) (
  input  logic [RW-1:0] src_i,
  input  logic          use_i,
  input  logic [RW-1:0] exm_dst_i,
  input  logic          exm_wen_i,
  input  hz_kind_e      exm_kind_i,
  input  logic [RW-1:0] mwb_dst_i,
  input  logic          mwb_wen_i,
  input  hz_kind_e      mwb_kind_i,
  output hz_sel_e       sel_o,
  output logic          hold_o
);
  localparam logic [RW-1:0] PC_ID = RW'(PC_REG);

  logic hit_exm, hit_mwb;

  always_comb begin
    hit_exm = use_i && exm_wen_i && (exm_dst_i == src_i) && (exm_dst_i != PC_ID);
    hit_mwb = use_i && mwb_wen_i && (mwb_dst_i == src_i) && (mwb_dst_i != PC_ID);
    // loads in execute cannot feed the next instruction; a multi-load's
    // last register arrives one cycle later still
    hold_o  = (hit_exm && (exm_kind_i != KIND_ALU)) ||
              (hit_mwb && (mwb_kind_i == KIND_MULTI));
    if (hit_exm)      sel_o = SEL_EXM;
    else if (hit_mwb) sel_o = SEL_MWB;
    else              sel_o = SEL_RF;
  end
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_fwd_pkg::*;
#(
  parameter int RW     = 4,
  parameter int N_SRC  = 3,
  parameter int PC_REG = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dec_valid_i,
  output logic                dec_ready_o,
  input  logic [N_SRC*RW-1:0] dec_src_i,
  input  logic [N_SRC-1:0]    dec_src_use_i,
  input  logic [RW-1:0]       dec_dst_i,
  input  logic                dec_wen_i,
  input  logic [1:0]          dec_kind_i,
  output logic                stall_o,
  output logic                ex_valid_o,
  output logic [2*N_SRC-1:0]  ex_fwd_sel_o
);
  localparam int SELW = 2 * N_SRC;

  logic          adv;
  logic [RW-1:0] exm_dst, mwb_dst;
  logic          exm_wen, mwb_wen;
  hz_kind_e      exm_kind, mwb_kind;
  logic [N_SRC-1:0] hold_vec;
  logic [SELW-1:0]  sel_next;

  hz_dest_pipe #(.RW(RW)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_i     (adv),
    .dst_i     (dec_dst_i),
    .wen_i     (dec_wen_i),
    .kind_i    (hz_kind_e'(dec_kind_i)),
    .exm_dst_o (exm_dst),
    .exm_wen_o (exm_wen),
    .exm_kind_o(exm_kind),
    .mwb_dst_o (mwb_dst),
    .mwb_wen_o (mwb_wen),
    .mwb_kind_o(mwb_kind)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    hz_sel_e sel_g;
    hz_src_check #(.RW(RW), .PC_REG(PC_REG)) u_chk (
      .src_i     (dec_src_i[g*RW +: RW]),
      .use_i     (dec_src_use_i[g]),
      .exm_dst_i (exm_dst),
      .exm_wen_i (exm_wen),
      .exm_kind_i(exm_kind),
      .mwb_dst_i (mwb_dst),
      .mwb_wen_i (mwb_wen),
      .mwb_kind_i(mwb_kind),
      .sel_o     (sel_g),
      .hold_o    (hold_vec[g])
    );
    assign sel_next[2*g +: 2] = sel_g;
  end

  assign dec_ready_o = ~|hold_vec;
  assign stall_o     = dec_valid_i & ~dec_ready_o;
  assign adv         = dec_valid_i & dec_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_valid_o   <= 1'b0;
      ex_fwd_sel_o <= '0;
    end else begin
      ex_valid_o   <= adv;
      ex_fwd_sel_o <= adv ? sel_next : '0;
    end
  end
endmodule

// File: rtl/hz_fwd_unit_chk.sv
module hz_fwd_unit_chk #(
  parameter int N_SRC = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dec_valid_i,
  input logic               dec_ready_o,
  input logic               stall_o,
  input logic               ex_valid_o,
  input logic [2*N_SRC-1:0] ex_fwd_sel_o
);
  logic [1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (stall_o) run_q <= (run_q == 2'd3) ? run_q : run_q + 2'd1;
    else              run_q <= '0;
  end

  // R11
  bubble_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> !ex_valid_o);

  // R11
  accept_reaches_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && dec_ready_o) |=> ex_valid_o);

  // R11
  stall_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> dec_valid_i);

  // R1
  idle_sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_valid_o |-> (ex_fwd_sel_o == '0));

  // R7
  stall_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (run_q < 2'd2));

  for (genvar g = 0; g < N_SRC; g++) begin : g_code
    // R12
    sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ex_fwd_sel_o[2*g +: 2] != 2'd3);
  end
endmodule

bind hz_fwd_unit hz_fwd_unit_chk #(.N_SRC(N_SRC)) u_fwd_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dec_valid_i (dec_valid_i),
  .dec_ready_o (dec_ready_o),
  .stall_o     (stall_o),
  .ex_valid_o  (ex_valid_o),
  .ex_fwd_sel_o(ex_fwd_sel_o)
);

// File: tb/tb_hz_fwd_unit.sv
module tb_hz_fwd_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid_i = 1'b0;
  logic        dec_ready_o;
  logic [11:0] dec_src_i = '0;
  logic [2:0]  dec_src_use_i = '0;
  logic [3:0]  dec_dst_i = '0;
  logic        dec_wen_i = 1'b0;
  logic [1:0]  dec_kind_i = '0;
  logic        stall_o;
  logic        ex_valid_o;
  logic [5:0]  ex_fwd_sel_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hz_fwd_unit dut (
    .clk(clk), .rst_n(rst_n),
    .dec_valid_i(dec_valid_i), .dec_ready_o(dec_ready_o),
    .dec_src_i(dec_src_i), .dec_src_use_i(dec_src_use_i),
    .dec_dst_i(dec_dst_i), .dec_wen_i(dec_wen_i), .dec_kind_i(dec_kind_i),
    .stall_o(stall_o), .ex_valid_o(ex_valid_o), .ex_fwd_sel_o(ex_fwd_sel_o)
  );

  // {src0, src1, src2, use[2:0], dst, wen, kind, expected stalls, expected sel}
  localparam int NV = 29;
  localparam logic [29:0] VEC [NV] = '{
    {4'd2, 4'd3, 4'd0, 3'b011, 4'd1, 1'b1, 2'd0, 2'd0, 6'b000000},
    {4'd5, 4'd1, 4'd0, 3'b011, 4'd4, 1'b1, 2'd0, 2'd0, 6'b000100}, // R2
    {4'd1, 4'd7, 4'd0, 3'b011, 4'd6, 1'b1, 2'd0, 2'd0, 6'b000010}, // R3
    {4'd6, 4'd4, 4'd1, 3'b111, 4'd4, 1'b1, 2'd0, 2'd0, 6'b001001}, // R12
    {4'd8, 4'd0, 4'd0, 3'b001, 4'd4, 1'b1, 2'd0, 2'd0, 6'b000000},
    {4'd4, 4'd0, 4'd0, 3'b001, 4'd9, 1'b1, 2'd0, 2'd0, 6'b000001}, // R4
    {4'd3, 4'd0, 4'd0, 3'b001, 4'd2, 1'b1, 2'd1, 2'd0, 6'b000000},
    {4'd2, 4'd0, 4'd0, 3'b001, 4'd5, 1'b1, 2'd0, 2'd1, 6'b000010}, // R5
    {4'd0, 4'd0, 4'd0, 3'b000, 4'd7, 1'b1, 2'd1, 2'd0, 6'b000000},
    {4'd11,4'd0, 4'd0, 3'b001, 4'd10,1'b1, 2'd0, 2'd0, 6'b000000},
    {4'd7, 4'd0, 4'd0, 3'b001, 4'd3, 1'b1, 2'd0, 2'd0, 6'b000010}, // R6
    {4'd13,4'd0, 4'd0, 3'b001, 4'd12,1'b1, 2'd2, 2'd0, 6'b000000},
    {4'd0, 4'd0, 4'd12,3'b100, 4'd1, 1'b1, 2'd0, 2'd2, 6'b000000}, // R7 adjacent
    {4'd0, 4'd0, 4'd0, 3'b000, 4'd11,1'b1, 2'd2, 2'd0, 6'b000000},
    {4'd14,4'd0, 4'd0, 3'b001, 4'd0, 1'b1, 2'd0, 2'd0, 6'b000000},
    {4'd0, 4'd11,4'd0, 3'b010, 4'd2, 1'b1, 2'd0, 2'd1, 6'b000000}, // R7 gap one
    {4'd0, 4'd0, 4'd0, 3'b000, 4'd8, 1'b0, 2'd0, 2'd0, 6'b000000},
    {4'd8, 4'd0, 4'd0, 3'b001, 4'd1, 1'b1, 2'd0, 2'd0, 6'b000000}, // R8
    {4'd0, 4'd0, 4'd0, 3'b000, 4'd3, 1'b0, 2'd1, 2'd0, 6'b000000},
    {4'd3, 4'd0, 4'd0, 3'b001, 4'd0, 1'b1, 2'd0, 2'd0, 6'b000000}, // R8 load
    {4'd0, 4'd0, 4'd0, 3'b000, 4'd15,1'b1, 2'd0, 2'd0, 6'b000000},
    {4'd15,4'd0, 4'd0, 3'b001, 4'd1, 1'b1, 2'd0, 2'd0, 6'b000000}, // R9
    {4'd0, 4'd0, 4'd0, 3'b000, 4'd15,1'b1, 2'd1, 2'd0, 6'b000000},
    {4'd0, 4'd15,4'd0, 3'b010, 4'd1, 1'b1, 2'd0, 2'd0, 6'b000000}, // R9 load
    {4'd0, 4'd0, 4'd0, 3'b000, 4'd6, 1'b1, 2'd0, 2'd0, 6'b000000},
    {4'd6, 4'd6, 4'd6, 3'b000, 4'd0, 1'b0, 2'd0, 2'd0, 6'b000000}, // R10
    {4'd6, 4'd6, 4'd6, 3'b111, 4'd0, 1'b0, 2'd0, 2'd0, 6'b101010}, // R12
    {4'd0, 4'd0, 4'd0, 3'b000, 4'd9, 1'b1, 2'd1, 2'd0, 6'b000000},
    {4'd9, 4'd0, 4'd0, 3'b000, 4'd0, 1'b0, 2'd0, 2'd0, 6'b000000}  // R10 load
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    dec_valid_i = 1'b0;
    dec_src_use_i = '0;
    dec_wen_i = 1'b0;
  endtask

  // call just after a falling edge; returns at a falling edge
  task automatic issue(input logic [29:0] v, input int idx);
    int n;
    dec_src_i     = {v[21:18], v[25:22], v[29:26]};
    dec_src_use_i = v[17:15];
    dec_dst_i     = v[14:11];
    dec_wen_i     = v[10];
    dec_kind_i    = v[9:8];
    dec_valid_i   = 1'b1;
    n = 0;
    #1;
    while (!dec_ready_o && n < 4) begin
      check(stall_o == 1'b1, "R11 stall with ready low", stall_o, 1);
      @(negedge clk);
      #1;
      check(ex_valid_o == 1'b0, "R11 bubble in execute", ex_valid_o, 0);
      n++;
    end
    @(negedge clk);
    check(n == int'(v[7:6]), $sformatf("R5/R7 stall count vec %0d", idx), n, int'(v[7:6]));
    check(ex_valid_o == 1'b1, $sformatf("R11 accepted vec %0d", idx), ex_valid_o, 1);
    check(ex_fwd_sel_o == v[5:0], $sformatf("R2/R3/R4/R6/R8/R9/R10/R12 select vec %0d", idx),
          ex_fwd_sel_o, v[5:0]);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ex_valid_o == 1'b0, "R1 ex_valid", ex_valid_o, 0);
    check(ex_fwd_sel_o == 6'd0, "R1 selects", ex_fwd_sel_o, 0);
    check(dec_ready_o == 1'b1, "R1 ready", dec_ready_o, 1);

    for (int i = 0; i < NV; i++) issue(VEC[i], i);

    // R11: load in execute, dependent presented with valid low
    issue({4'd0, 4'd0, 4'd0, 3'b000, 4'd5, 1'b1, 2'd1, 2'd0, 6'b000000}, 100);
    dec_src_i = 12'd5; dec_src_use_i = 3'b001; dec_valid_i = 1'b0;
    #1;
    check(dec_ready_o == 1'b0, "R11 ready low on hazard", dec_ready_o, 0);
    check(stall_o == 1'b0, "R11 no stall without valid", stall_o, 0);
    idle();
    @(negedge clk);
    check(ex_valid_o == 1'b0, "R11 idle gives bubble", ex_valid_o, 0);

    // R1: reset clears a pending multi-load hazard
    issue({4'd0, 4'd0, 4'd0, 3'b000, 4'd7, 1'b1, 2'd2, 2'd0, 6'b000000}, 101);
    rst_n = 1'b0;
    #1;
    check(ex_valid_o == 1'b0, "R1 reset clears execute", ex_valid_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    issue({4'd7, 4'd0, 4'd0, 3'b001, 4'd1, 1'b1, 2'd0, 2'd0, 6'b000000}, 102); // R1
    idle();
    @(negedge clk);
    check(ex_valid_o == 1'b0, "R1 drained", ex_valid_o, 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule